// File: doc/BRIEF.md
# Trap-Level Banked Control Register File

This block holds a processor's control and status words behind one indexed access port. A 5-bit index picks a register. The caller raises `acc_en` for one cycle and sets `acc_wr` to choose a write or a read. Read data and an error pulse come back on the next clock edge.

Five of the registers are trap-save registers, and each has one copy per trap level. Every access to them uses the copy at the current trap level minus one. The other registers are single words: trap base, hyper trap base, processor state, hyper state, soft-interrupt, pending hyper-interrupt, trap level, global level, window pointer and a read-only version word.

From the trap level and the little-endian bit of the processor state word, the block also keeps two registered address-space identifiers: one for instruction fetch and one for data access. These identifiers are refreshed in the same edge that writes either input.

Index map: 0 trap PC, 1 trap next-PC, 2 trap state, 3 trap type (9 bits), 4 hyper trap state, 5 trap base, 6 processor state (12 bits), 7 trap level, 8 global level, 9 hyper state (12 bits), 10 hyper trap base, 11 soft-interrupt, 12 pending hyper-interrupt, 13 window pointer, 14 version. Indices 15 to 31 are unimplemented. Identifier codes: PRIMARY 0x80, PRIMARY_LITTLE 0x88, NUCLEUS 0x04, NUCLEUS_LITTLE 0x0C, REAL 0x14.

Top module: `ctl_rf_top`

## Requirements
- R1: After reset, the registers hold these values: trap level = MAX_TL (6); global level = MAX_GL (3); processor state = 0x010 (enable bit 4 set, little-endian bit 9 clear); hyper state = 0x024 (bit 5 set, bit 2 set, bit 0 clear). Soft-interrupt, pending hyper-interrupt, trap base, hyper trap base and window pointer are 0. In the trap-type copy for level MAX_TL, the value is 0x001, and every other copy is 0. Both identifiers are REAL.
- R2: A read or write of indices 0 to 4 uses the copy selected by trap level minus one. Copies at other levels keep their values.
- R3: When the trap level is 0, an access to indices 0 to 4 raises the error pulse. Such a read returns 0, and such a write changes nothing.
- R4: A write to the trap base (index 5) stores the value with bits [14:0] forced to zero.
- R5: A read of index 14 returns NWIN in bits [7:0], MAX_TL in [15:8] and MAX_GL in [23:16], with 0 above. A write to index 14 changes nothing and raises no error.
- R6: When the trap level is 0, both identifiers are PRIMARY (0x80), or PRIMARY_LITTLE (0x88) when bit 9 of the processor state is set.
- R7: When the trap level is from 1 to MAX_PTL (2), the instruction identifier is NUCLEUS (0x04). The data identifier is NUCLEUS, or NUCLEUS_LITTLE (0x0C) when bit 9 is set.
- R8: When the trap level is above MAX_PTL, both identifiers are REAL (0x14).
- R9: The identifiers change only in the edge that writes index 6 or 7, and they then reflect the newly written value.
- R10: An access to indices 15 to 31 raises the error pulse for one cycle. Such a read returns 0, and such a write changes no state.
- R11: A write of the trap level or global level above its maximum stores the maximum. The window pointer stores the written value modulo NWIN.
- R12: Read data is registered: it updates in the edge after a read access and otherwise holds. A write becomes visible to a read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 5 | Register index |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| err | output | 1 | One-cycle error pulse for an illegal access |
| inst_asi | output | 8 | Implicit instruction address-space identifier |
| data_asi | output | 8 | Implicit data address-space identifier |

## Verification
A wrong trap level inside the block becomes visible at the port in one cycle. Both identifier outputs follow that state directly, and a following banked read returns a copy from the wrong level. A wrong write decode can stay hidden until some later read of the corrupted register. For that reason the bench keeps a full model of every register and copy, and it compares all four outputs on every clock. Any divergence is reported on the first cycle in which it reaches a port, not only at directed checkpoints.

// File: rtl/ctl_rf_pkg.sv
`timescale 1ns/1ps
package ctl_rf_pkg;
    localparam int NUM_IDX    = 15;
    localparam int NUM_BANKED = 5;
    localparam int PSW_W      = 12;
    localparam int TT_W       = 9;
    localparam int CLE_BIT    = 9;
    localparam int PEF_BIT    = 4;
    localparam int HP_RED     = 5;
    localparam int HP_PRIV    = 2;
    localparam int HP_TLZ     = 0;

    localparam logic [TT_W-1:0] POR_TT = 9'h001;

    localparam logic [7:0] ASI_PRIM    = 8'h80;
    localparam logic [7:0] ASI_PRIM_LE = 8'h88;
    localparam logic [7:0] ASI_NUC     = 8'h04;
    localparam logic [7:0] ASI_NUC_LE  = 8'h0C;
    localparam logic [7:0] ASI_REAL    = 8'h14;

    typedef enum logic [4:0] {
        IX_TPC    = 5'd0,
        IX_TNPC   = 5'd1,
        IX_TSTATE = 5'd2,
        IX_TTYPE  = 5'd3,
        IX_HTSTAT = 5'd4,
        IX_TBASE  = 5'd5,
        IX_PSW    = 5'd6,
        IX_TLVL   = 5'd7,
        IX_GLVL   = 5'd8,
        IX_HPSW   = 5'd9,
        IX_HTBASE = 5'd10,
        IX_SOFTI  = 5'd11,
        IX_HPEND  = 5'd12,
        IX_WINP   = 5'd13,
        IX_VER    = 5'd14
    } ctl_idx_e;

    localparam logic [PSW_W-1:0] PSW_RST  = PSW_W'(1) << PEF_BIT;
    localparam logic [PSW_W-1:0] HPSW_RST = (PSW_W'(1) << HP_RED) | (PSW_W'(1) << HP_PRIV);
endpackage

// File: rtl/ctl_bank.sv
`timescale 1ns/1ps
module ctl_bank #(
    parameter int            W       = 64,
    parameter int            DEPTH   = 6,
    parameter int            SW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter logic [W-1:0]  TOP_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [W-1:0] RST_V = (i == DEPTH - 1) ? TOP_RST : '0;
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= RST_V;
            else if (we && (sel == SW'(i)))
                slot[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (sel == SW'(i))
                rdata = slot[i];
    end
endmodule

// File: rtl/ctl_asi_sel.sv
`timescale 1ns/1ps
module ctl_asi_sel
    import ctl_rf_pkg::*;
#(
    parameter int MAX_PTL = 2,
    parameter int TLW     = 3
) (
    input  logic [TLW-1:0] tl,
    input  logic           little,
    output logic [7:0]     inst_id,
    output logic [7:0]     data_id
);
    always_comb begin
        if (tl == '0) begin
            inst_id = little ? ASI_PRIM_LE : ASI_PRIM;
            data_id = inst_id;
        end else if (tl <= TLW'(MAX_PTL)) begin
            inst_id = ASI_NUC;
            data_id = little ? ASI_NUC_LE : ASI_NUC;
        end else begin
            inst_id = ASI_REAL;
            data_id = ASI_REAL;
        end
    end
endmodule

// File: rtl/ctl_decode.sv
`timescale 1ns/1ps
module ctl_decode
    import ctl_rf_pkg::*;
(
    input  logic [4:0]         idx,
    input  logic               tl_zero,
    output logic [NUM_IDX-1:0] sel,
    output logic               bad
);
    logic known;
    logic banked;

    assign known  = (idx < 5'(NUM_IDX));
    assign banked = (idx < 5'(NUM_BANKED));
    assign bad    = !known || (banked && tl_zero);

    for (genvar k = 0; k < NUM_IDX; k++) begin : g_sel
        assign sel[k] = (idx == 5'(k));
    end
endmodule

// File: rtl/ctl_rf_top.sv
`timescale 1ns/1ps
module ctl_rf_top
    import ctl_rf_pkg::*;
#(
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2,
    parameter int MAX_GL  = 3,
    parameter int NWIN    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic [4:0]  acc_idx,
    input  logic [63:0] wr_data,
    output logic [63:0] rd_data,
    output logic        err,
    output logic [7:0]  inst_asi,
    output logic [7:0]  data_asi
);
    localparam int XLEN = 64;
    localparam int TLW  = $clog2(MAX_TL + 1);
    localparam int GLW  = $clog2(MAX_GL + 1);
    localparam int CWW  = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int BSW  = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;
    localparam logic [XLEN-1:0] VER_WORD =
        XLEN'({8'(MAX_GL), 8'(MAX_TL), 8'(NWIN)});
    localparam logic [XLEN-1:0] TBA_MASK = ~XLEN'(16'h7FFF);

    logic [TLW-1:0]   tl_q;
    logic [GLW-1:0]   gl_q;
    logic [CWW-1:0]   cwp_q;
    logic [PSW_W-1:0] pstate_q;
    logic [PSW_W-1:0] hpstate_q;
    logic [XLEN-1:0]  tba_q;
    logic [XLEN-1:0]  htba_q;
    logic [XLEN-1:0]  softint_q;
    logic [XLEN-1:0]  hintp_q;
    logic [XLEN-1:0]  rd_q;
    logic             err_q;
    logic [7:0]       iasi_q;
    logic [7:0]       dasi_q;

    logic [NUM_IDX-1:0] sel;
    logic               bad;
    logic               wr_ok;
    logic               rd_go;
    logic [NUM_IDX-1:0] we;

    ctl_decode u_dec (
        .idx     (acc_idx),
        .tl_zero (tl_q == '0),
        .sel     (sel),
        .bad     (bad)
    );

    assign wr_ok = acc_en && acc_wr && !bad;
    assign rd_go = acc_en && !acc_wr;
    assign we    = wr_ok ? sel : '0;

    // Banked trap-save copies, addressed by trap level minus one
    logic [TLW-1:0]  tl_dec;
    logic [BSW-1:0]  bank_sel;
    logic [XLEN-1:0] bank_rv [NUM_BANKED];

    assign tl_dec   = tl_q - TLW'(1);
    assign bank_sel = tl_dec[BSW-1:0];

    for (genvar b = 0; b < NUM_BANKED; b++) begin : g_bank
        localparam int BW = (b == int'(IX_TTYPE)) ? TT_W : XLEN;
        localparam logic [BW-1:0] TOP_V = (b == int'(IX_TTYPE)) ? BW'(POR_TT) : '0;
        logic [BW-1:0] rv;
        ctl_bank #(
            .W       (BW),
            .DEPTH   (MAX_TL),
            .SW      (BSW),
            .TOP_RST (TOP_V)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we[b]),
            .sel   (bank_sel),
            .wdata (wr_data[BW-1:0]),
            .rdata (rv)
        );
        assign bank_rv[b] = XLEN'(rv);
    end

    // Clamped and wrapped write values
    logic [TLW-1:0] tl_wval;
    logic [GLW-1:0] gl_wval;
    logic [CWW-1:0] cwp_wval;

    assign tl_wval  = (wr_data > XLEN'(MAX_TL)) ? TLW'(MAX_TL) : wr_data[TLW-1:0];
    assign gl_wval  = (wr_data > XLEN'(MAX_GL)) ? GLW'(MAX_GL) : wr_data[GLW-1:0];
    assign cwp_wval = CWW'(wr_data % XLEN'(NWIN));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q      <= TLW'(MAX_TL);
            gl_q      <= GLW'(MAX_GL);
            cwp_q     <= '0;
            pstate_q  <= PSW_RST;
            hpstate_q <= HPSW_RST;
            tba_q     <= '0;
            htba_q    <= '0;
            softint_q <= '0;
            hintp_q   <= '0;
        end else begin
            if (we[IX_TLVL])   tl_q      <= tl_wval;
            if (we[IX_GLVL])   gl_q      <= gl_wval;
            if (we[IX_WINP])   cwp_q     <= cwp_wval;
            if (we[IX_PSW])    pstate_q  <= wr_data[PSW_W-1:0];
            if (we[IX_HPSW])   hpstate_q <= wr_data[PSW_W-1:0];
            if (we[IX_TBASE])  tba_q     <= wr_data & TBA_MASK;
            if (we[IX_HTBASE]) htba_q    <= wr_data;
            if (we[IX_SOFTI])  softint_q <= wr_data;
            if (we[IX_HPEND])  hintp_q   <= wr_data;
        end
    end

    // Implicit identifiers: recomputed from post-write values
    logic [TLW-1:0] tl_nx;
    logic           cle_nx;
    logic [7:0]     iasi_nx;
    logic [7:0]     dasi_nx;

    assign tl_nx  = we[IX_TLVL] ? tl_wval : tl_q;
    assign cle_nx = we[IX_PSW] ? wr_data[CLE_BIT] : pstate_q[CLE_BIT];

    ctl_asi_sel #(
        .MAX_PTL (MAX_PTL),
        .TLW     (TLW)
    ) u_asi (
        .tl      (tl_nx),
        .little  (cle_nx),
        .inst_id (iasi_nx),
        .data_id (dasi_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iasi_q <= ASI_REAL;
            dasi_q <= ASI_REAL;
        end else if (we[IX_TLVL] || we[IX_PSW]) begin
            iasi_q <= iasi_nx;
            dasi_q <= dasi_nx;
        end
    end

    // Read path
    logic [XLEN-1:0] rd_nx;

    always_comb begin
        case (acc_idx)
            IX_TPC:    rd_nx = bank_rv[0];
            IX_TNPC:   rd_nx = bank_rv[1];
            IX_TSTATE: rd_nx = bank_rv[2];
            IX_TTYPE:  rd_nx = bank_rv[3];
            IX_HTSTAT: rd_nx = bank_rv[4];
            IX_TBASE:  rd_nx = tba_q;
            IX_PSW:    rd_nx = XLEN'(pstate_q);
            IX_TLVL:   rd_nx = XLEN'(tl_q);
            IX_GLVL:   rd_nx = XLEN'(gl_q);
            IX_HPSW:   rd_nx = XLEN'(hpstate_q);
            IX_HTBASE: rd_nx = htba_q;
            IX_SOFTI:  rd_nx = softint_q;
            IX_HPEND:  rd_nx = hintp_q;
            IX_WINP:   rd_nx = XLEN'(cwp_q);
            IX_VER:    rd_nx = VER_WORD;
            default:   rd_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= acc_en && bad;
            if (rd_go)
                rd_q <= bad ? '0 : rd_nx;
        end
    end

    assign rd_data  = rd_q;
    assign err      = err_q;
    assign inst_asi = iasi_q;
    assign data_asi = dasi_q;
endmodule

// File: rtl/ctl_rf_chk.sv
`timescale 1ns/1ps
module ctl_rf_chk
    import ctl_rf_pkg::*;
#(
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2,
    parameter int MAX_GL  = 3,
    parameter int NWIN    = 8,
    parameter int TLW     = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           acc_en,
    input logic           acc_wr,
    input logic [4:0]     acc_idx,
    input logic [63:0]    rd_data,
    input logic           err,
    input logic [7:0]     inst_asi,
    input logic [7:0]     data_asi,
    input logic [TLW-1:0] tl_q,
    input logic [63:0]    tba_q
);
    localparam logic [63:0] VER_W = 64'({8'(MAX_GL), 8'(MAX_TL), 8'(NWIN)});

    AST_TL_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        tl_q <= TLW'(MAX_TL)); // R11
    AST_TBA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tba_q[14:0] == 15'd0); // R4
    AST_REAL_ABOVE_PTL: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_q > TLW'(MAX_PTL)) |-> (inst_asi == ASI_REAL && data_asi == ASI_REAL)); // R8
    AST_NUCLEUS_INST: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_q != '0 && tl_q <= TLW'(MAX_PTL)) |-> (inst_asi == ASI_NUC)); // R7
    AST_PRIMARY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_q == '0) |-> (inst_asi == data_asi)); // R6
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(acc_en)); // R10
    AST_VER_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_idx == 5'd14) |=> (rd_data == VER_W && !err)); // R5
    AST_WRITE_HOLDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr) |=> $stable(rd_data)); // R12
    AST_ASI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && acc_wr && (acc_idx == 5'd6 || acc_idx == 5'd7))
        |=> ($stable(inst_asi) && $stable(data_asi))); // R9
endmodule

bind ctl_rf_top ctl_rf_chk #(
    .MAX_TL  (MAX_TL),
    .MAX_PTL (MAX_PTL),
    .MAX_GL  (MAX_GL),
    .NWIN    (NWIN),
    .TLW     (TLW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_idx  (acc_idx),
    .rd_data  (rd_data),
    .err      (err),
    .inst_asi (inst_asi),
    .data_asi (data_asi),
    .tl_q     (tl_q),
    .tba_q    (tba_q)
);

// File: tb/ctl_rf_top_test.sv
`timescale 1ns/1ps
module ctl_rf_top_test;
    localparam int MTL = 6;
    localparam int MPTL = 2;
    localparam int MGL = 3;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [4:0]  acc_idx = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        err;
    logic [7:0]  inst_asi;
    logic [7:0]  data_asi;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctl_rf_top uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_idx(acc_idx), .wr_data(wr_data), .rd_data(rd_data),
        .err(err), .inst_asi(inst_asi), .data_asi(data_asi)
    );

    // Behavioural reference state
    logic [63:0] m_bank [5][MTL];
    logic [63:0] m_tba, m_htba, m_soft, m_hint;
    int          m_tl, m_gl, m_cwp;
    logic [11:0] m_ps, m_hps;
    logic [63:0] e_rd;
    logic        e_err;
    logic [7:0]  e_ia, e_da;

    function automatic void id_pair(input int tl, input bit le,
                                    output logic [7:0] ia, output logic [7:0] da);
        if (tl == 0) begin
            ia = le ? 8'h88 : 8'h80; da = ia;
        end else if (tl <= MPTL) begin
            ia = 8'h04; da = le ? 8'h0C : 8'h04;
        end else begin
            ia = 8'h14; da = 8'h14;
        end
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 5; b++)
            for (int l = 0; l < MTL; l++) m_bank[b][l] = 64'd0;
        m_bank[3][MTL-1] = 64'd1;
        m_tba = 0; m_htba = 0; m_soft = 0; m_hint = 0;
        m_tl = MTL; m_gl = MGL; m_cwp = 0;
        m_ps = 12'h010; m_hps = 12'h024;
        e_rd = 0; e_err = 0; e_ia = 8'h14; e_da = 8'h14;
    endtask

    function automatic logic [63:0] model_read(input int ix);
        case (ix)
            0, 1, 2, 3, 4: return m_bank[ix][m_tl-1];
            5:  return m_tba;
            6:  return 64'(m_ps);
            7:  return 64'(m_tl);
            8:  return 64'(m_gl);
            9:  return 64'(m_hps);
            10: return m_htba;
            11: return m_soft;
            12: return m_hint;
            13: return 64'(m_cwp);
            14: return 64'h0000_0000_0003_0608;
            default: return 64'd0;
        endcase
    endfunction

    task automatic model_step(input bit en, input bit wr, input int ix, input logic [63:0] d);
        bit bad;
        bad = (ix > 14) || (ix < 5 && m_tl == 0);
        e_err = en && bad;
        if (en && !wr) e_rd = bad ? 64'd0 : model_read(ix);
        if (en && wr && !bad) begin
            case (ix)
                0, 1, 2, 4: m_bank[ix][m_tl-1] = d;
                3:  m_bank[3][m_tl-1] = d & 64'h1FF;
                5:  m_tba = d & ~64'h7FFF;
                6:  m_ps = d[11:0];
                7:  m_tl = (d > 64'(MTL)) ? MTL : int'(d);
                8:  m_gl = (d > 64'(MGL)) ? MGL : int'(d);
                9:  m_hps = d[11:0];
                10: m_htba = d;
                11: m_soft = d;
                12: m_hint = d;
                13: m_cwp = int'(d % 64'(NW));
                default: ;
            endcase
            if (ix == 6 || ix == 7) id_pair(m_tl, m_ps[9], e_ia, e_da);
        end
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (rd_data !== e_rd) begin
            n_bad++; $display("FAIL %s rd_data got %h exp %h", tag, rd_data, e_rd);
        end
        n_cmp++;
        if (err !== e_err) begin
            n_bad++; $display("FAIL %s err got %b exp %b", tag, err, e_err);
        end
        n_cmp++;
        if (inst_asi !== e_ia) begin
            n_bad++; $display("FAIL %s inst_asi got %h exp %h", tag, inst_asi, e_ia);
        end
        n_cmp++;
        if (data_asi !== e_da) begin
            n_bad++; $display("FAIL %s data_asi got %h exp %h", tag, data_asi, e_da);
        end
    endtask

    task automatic step(input string tag, input bit en, input bit wr,
                        input int ix, input logic [63:0] d);
        acc_en = en; acc_wr = wr; acc_idx = 5'(ix); wr_data = d;
        @(posedge clk);
        #1;
        model_step(en, wr, ix, d);
        acc_en = 1'b0; acc_wr = 1'b0;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rd(input string tag, input int ix);
        step(tag, 1'b1, 1'b0, ix, 64'd0);
    endtask

    task automatic wr(input string tag, input int ix, input logic [63:0] d);
        step(tag, 1'b1, 1'b1, ix, d);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 idle after reset");
        // R1 reset values
        rd("R1 tl", 7); rd("R1 gl", 8); rd("R1 psw", 6); rd("R1 hpsw", 9);
        rd("R1 softint", 11); rd("R1 hpend", 12); rd("R1 ttype top", 3);
        rd("R1 tpc top", 0); rd("R1 tbase", 5);
        // R5 version
        rd("R5 version", 14);
        wr("R5 version write", 14, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R5 version after write", 14);
        // R4 trap base masking
        wr("R4 tbase write", 5, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R4 tbase read", 5);
        wr("R4 tbase write2", 5, 64'h0000_1234_5678_9ABC);
        rd("R4 tbase read2", 5);
        // R2 banked per level
        for (int l = 1; l <= MTL; l++) begin
            wr("R2 set tl", 7, 64'(l));
            for (int b = 0; b < 5; b++)
                wr("R2 bank write", b, 64'hA5A5_0000_0000_0000 | 64'(l * 16 + b) | 64'h3_0000);
        end
        for (int l = MTL; l >= 1; l--) begin
            wr("R2 set tl back", 7, 64'(l));
            for (int b = 0; b < 5; b++) rd("R2 bank read", b);
        end
        // R3 banked at level zero
        wr("R6 tl zero", 7, 64'd0);
        rd("R3 tpc at tl0", 0);
        wr("R3 tstate write at tl0", 2, 64'h1111);
        rd("R3 ttype at tl0", 3);
        wr("R3 tl one", 7, 64'd1);
        rd("R3 tstate unchanged", 2);
        // R6 R7 R8 identifiers
        wr("R6 tl0 again", 7, 64'd0);
        wr("R6 cle set", 6, 64'h200);
        wr("R6 cle clear", 6, 64'h010);
        wr("R6 cle set2", 6, 64'h210);
        wr("R7 tl1 little", 7, 64'd1);
        wr("R7 tl2 little", 7, 64'd2);
        wr("R7 cle clear", 6, 64'h010);
        wr("R8 tl3", 7, 64'd3);
        wr("R8 cle set at tl3", 6, 64'h200);
        wr("R8 tl max", 7, 64'd6);
        // R9 unrelated writes leave identifiers
        wr("R9 gl write", 8, 64'd1);
        wr("R9 hpsw write", 9, 64'hFFF);
        wr("R9 tl1", 7, 64'd1);
        wr("R9 softint", 11, 64'hDEAD);
        // R10 unimplemented
        rd("R10 read idx 20", 20);
        wr("R10 write idx 31", 31, 64'hFFFF);
        wr("R10 write idx 15", 15, 64'h1234);
        rd("R10 read idx 15", 15);
        rd("R10 softint unchanged", 11);
        rd("R10 tl unchanged", 7);
        // R11 clamping and wrap
        wr("R11 tl above max", 7, 64'd9);
        rd("R11 tl clamp", 7);
        wr("R11 gl above max", 8, 64'd7);
        rd("R11 gl clamp", 8);
        wr("R11 cwp wrap", 13, 64'd13);
        rd("R11 cwp read", 13);
        wr("R11 huge tl", 7, 64'h8000_0000_0000_0002);
        rd("R11 huge tl read", 7);
        // R12 timing: back-to-back and idle hold
        rd("R12 b2b a", 12); rd("R12 b2b b", 10); rd("R12 b2b c", 14);
        step("R12 idle hold", 1'b0, 1'b0, 0, 64'd0);
        wr("R12 write then read", 10, 64'hCAFE_F00D);
        rd("R12 read new", 10);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule